// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits next to an in-order processor core that executes a mix of 16-bit and 32-bit instructions. It watches every instruction the core retires and decides whether a pending external interrupt request may be taken at the resulting instruction break. Only breaks that land on a 32-bit word boundary qualify. The one exception is a taken 16-bit branch, after which the request may be taken at once.

When a request is accepted, the block runs the hardware part of exception entry. It saves the three status bits (supervisor-stack select, interrupt enable, carry) into their backup copies and clears the live bits. It stores the resume address, word-aligned, in the backup PC. It then redirects the core to the entry vector, and the vector address depends on whether flash erase/write mode is active. A return strobe reverses the process: it restores the status bits from the backups and redirects the core to the backup PC.

The control is a three-state machine. **S_RUN** is the normal state. The transition *accept* leads from S_RUN to **S_ENTER**, and the transition *return* leads from S_RUN to **S_RETURN**. Each of S_ENTER and S_RETURN lasts exactly one cycle, during which the redirect is presented. The transition *resume* leads from either state back to S_RUN.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, SM, IE, C, the three backup bits and the backup PC are all zero, and neither the redirect nor the acknowledge is asserted.
- R2: A retirement (retire_valid=1) is accepted when irq_req=1, IE=1 and the break is on a word boundary. A word-boundary break is a 32-bit instruction (retire_is32=1), a 16-bit instruction with retire_addr[1]=1, or a taken 16-bit branch (retire_branch=1). In the cycle after the retirement, redirect_valid and irq_ack are both 1 for exactly one cycle.
- R3: A 16-bit non-branch instruction whose address has retire_addr[1]=0 is never accepted, whatever the request and IE are.
- R4: While IE=0, no request is accepted.
- R5: On acceptance, BSM, BIE and BC take the values that SM, IE and C held just before entry. SM, IE and C read 0 from the redirect cycle onward.
- R6: On acceptance, the backup PC is loaded with retire_next_pc, with its two low bits forced to zero.
- R7: The entry target is 0x0000_0080 when flash_mode=0 and 0x0080_4000 when flash_mode=1. flash_mode is sampled in the retirement cycle.
- R8: The request is level-sensitive and is not held. A request that is low at the first acceptable boundary after it rose is not taken.
- R9: A return strobe (rte_strobe=1) in the running state copies BSM, BIE and BC back into SM, IE and C. In the next cycle it gives a one-cycle redirect to the backup PC with irq_ack=0. When a return strobe and an acceptable request arrive together, the return wins.
- R10: psw_wr_en=1 loads SM, IE and C from psw_wr_data bits 2, 1 and 0 respectively. The write is dropped in a cycle where an entry or a return is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_addr | input | 32 | Address of the retiring instruction |
| retire_is32 | input | 1 | Retiring instruction is 32 bits long |
| retire_branch | input | 1 | Retiring instruction is a taken branch |
| retire_next_pc | input | 32 | Address of the next instruction to execute |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| flash_mode | input | 1 | Flash erase/write mode is active |
| rte_strobe | input | 1 | Return-from-exception retires this cycle |
| psw_wr_en | input | 1 | Core writes the status bits |
| psw_wr_data | input | 3 | New status bits {SM, IE, C} |
| redirect_valid | output | 1 | Core must fetch from redirect_target |
| redirect_target | output | 32 | Fetch address for the redirect |
| irq_ack | output | 1 | Interrupt accepted (one cycle, with redirect) |
| status_sm | output | 1 | Live SM bit |
| status_ie | output | 1 | Live IE bit |
| status_c | output | 1 | Live C bit |
| bak_sm | output | 1 | Backup SM bit |
| bak_ie | output | 1 | Backup IE bit |
| bak_c | output | 1 | Backup C bit |
| bpc | output | 32 | Backup PC |

## Verification
The hardest situation to reach from the ports is a request that is lost. The request must be high across a mid-word break and then drop before the next word boundary. The stimulus sets this up with a first-half 16-bit retirement while the request is high, followed by the second-half retirement with the request low. A later 32-bit retirement with the request high then shows that acceptance still works. Two other collisions are driven directly: a status write in the same cycle as an accept, and a return strobe together with an acceptable request. In both cases the bench checks which update won by reading the live and backup status bits.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_ENTER  = 2'd1,
        S_RETURN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } psw_bits_t;

endpackage

// File: rtl/irq_boundary_check.sv
module irq_boundary_check (
    input  logic retire_valid,
    input  logic half_sel,
    input  logic is32,
    input  logic taken_branch,
    output logic break_ok
);
    // A break is word aligned after a full-width instruction or after a
    // halfword that fills the second half of a word. A taken halfword
    // branch also qualifies.
    always_comb begin
        break_ok = retire_valid && (is32 || half_sel || taken_branch);
    end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_entry,
    input  logic              do_return,
    input  logic              wr_en,
    input  psw_bits_t         wr_data,
    input  logic [ADDR_W-1:0] save_pc,
    output psw_bits_t         cur,
    output psw_bits_t         bak,
    output logic [ADDR_W-1:0] bpc
);
    localparam logic [ALIGN_BITS-1:0] ALIGN_ZERO = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
            bak <= '0;
            bpc <= '0;
        end else if (do_entry) begin
            bak <= cur;
            cur <= '0;
            bpc <= {save_pc[ADDR_W-1:ALIGN_BITS], ALIGN_ZERO};
        end else if (do_return) begin
            cur <= bak;
        end else if (wr_en) begin
            cur <= wr_data;
        end
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] VEC_NORMAL = 32'h0000_0080,
    parameter logic [ADDR_W-1:0] VEC_FLASH  = 32'h0080_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              break_ok,
    input  logic              irq_req,
    input  logic              ie,
    input  logic              rte_strobe,
    input  logic              flash_mode,
    input  logic [ADDR_W-1:0] bpc,
    output logic              do_entry,
    output logic              do_return,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_target,
    output logic              irq_ack
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] target_q, target_d;

    // Transition decisions (accept / return) taken only while running.
    always_comb begin
        do_return = (state_q == S_RUN) && rte_strobe;
        do_entry  = (state_q == S_RUN) && !rte_strobe && break_ok && irq_req && ie;
    end

    // Next state and latched target.
    always_comb begin
        state_d  = state_q;
        target_d = target_q;
        unique case (state_q)
            S_RUN: begin
                if (do_return) begin
                    state_d  = S_RETURN;
                    target_d = bpc;
                end else if (do_entry) begin
                    state_d  = S_ENTER;
                    target_d = flash_mode ? VEC_FLASH : VEC_NORMAL;
                end
            end
            S_ENTER:  state_d = S_RUN;
            S_RETURN: state_d = S_RUN;
            default:  state_d = S_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_RUN;
            target_q <= '0;
        end else begin
            state_q  <= state_d;
            target_q <= target_d;
        end
    end

    // Outputs by state.
    always_comb begin
        redirect_valid  = 1'b0;
        irq_ack         = 1'b0;
        redirect_target = target_q;
        unique case (state_q)
            S_RUN: ;
            S_ENTER: begin
                redirect_valid = 1'b1;
                irq_ack        = 1'b1;
            end
            S_RETURN: redirect_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] VEC_NORMAL = 32'h0000_0080,
    parameter logic [ADDR_W-1:0] VEC_FLASH  = 32'h0080_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_valid,
    input  logic [ADDR_W-1:0] retire_addr,
    input  logic              retire_is32,
    input  logic              retire_branch,
    input  logic [ADDR_W-1:0] retire_next_pc,
    input  logic              irq_req,
    input  logic              flash_mode,
    input  logic              rte_strobe,
    input  logic              psw_wr_en,
    input  logic [2:0]        psw_wr_data,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_target,
    output logic              irq_ack,
    output logic              status_sm,
    output logic              status_ie,
    output logic              status_c,
    output logic              bak_sm,
    output logic              bak_ie,
    output logic              bak_c,
    output logic [ADDR_W-1:0] bpc
);
    localparam int ALIGN_BITS = 2;

    logic      break_ok, do_entry, do_return;
    psw_bits_t cur, bak, wr_bits;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{retire_addr[ADDR_W-1:ALIGN_BITS], retire_addr[0]};

    assign wr_bits = '{sm: psw_wr_data[2], ie: psw_wr_data[1], c: psw_wr_data[0]};

    irq_boundary_check u_bound (
        .retire_valid (retire_valid),
        .half_sel     (retire_addr[1]),
        .is32         (retire_is32),
        .taken_branch (retire_branch),
        .break_ok     (break_ok)
    );

    irq_entry_fsm #(
        .ADDR_W     (ADDR_W),
        .VEC_NORMAL (VEC_NORMAL),
        .VEC_FLASH  (VEC_FLASH)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .break_ok        (break_ok),
        .irq_req         (irq_req),
        .ie              (cur.ie),
        .rte_strobe      (rte_strobe),
        .flash_mode      (flash_mode),
        .bpc             (bpc),
        .do_entry        (do_entry),
        .do_return       (do_return),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target),
        .irq_ack         (irq_ack)
    );

    irq_status_regs #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_entry  (do_entry),
        .do_return (do_return),
        .wr_en     (psw_wr_en),
        .wr_data   (wr_bits),
        .save_pc   (retire_next_pc),
        .cur       (cur),
        .bak       (bak),
        .bpc       (bpc)
    );

    assign status_sm = cur.sm;
    assign status_ie = cur.ie;
    assign status_c  = cur.c;
    assign bak_sm    = bak.sm;
    assign bak_ie    = bak.ie;
    assign bak_c     = bak.c;
endmodule

// File: rtl/irq_entry_seq_checker.sv
module irq_entry_seq_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              retire_valid,
    input logic [ADDR_W-1:0] retire_addr,
    input logic              retire_is32,
    input logic              retire_branch,
    input logic              rte_strobe,
    input logic              status_sm,
    input logic              status_ie,
    input logic              status_c,
    input logic              bak_ie,
    input logic [ADDR_W-1:0] bpc,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_target,
    input logic              irq_ack
);
    a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    a_r2_ack_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> redirect_valid);

    a_r3_midword_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !retire_is32 && !retire_addr[1] && !retire_branch) |=> !irq_ack);

    a_r4_ie_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_ie && !redirect_valid) |=> !irq_ack);

    a_r5_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (!status_sm && !status_ie && !status_c && bak_ie));

    a_r7_vector_choice: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (redirect_target == 32'h0000_0080 || redirect_target == 32'h0080_4000));

    a_r9_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !irq_ack) |-> (redirect_target == bpc));

    a_r9_return_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rte_strobe && !redirect_valid |=> !irq_ack);
endmodule

bind irq_entry_seq irq_entry_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .retire_valid    (retire_valid),
    .retire_addr     (retire_addr),
    .retire_is32     (retire_is32),
    .retire_branch   (retire_branch),
    .rte_strobe      (rte_strobe),
    .status_sm       (status_sm),
    .status_ie       (status_ie),
    .status_c        (status_c),
    .bak_ie          (bak_ie),
    .bpc             (bpc),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .irq_ack         (irq_ack)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    typedef struct {
        logic [31:0] target;
        logic        ack;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic [31:0] retire_addr = '0;
    logic        retire_is32 = 1'b0;
    logic        retire_branch = 1'b0;
    logic [31:0] retire_next_pc = '0;
    logic        irq_req = 1'b0;
    logic        flash_mode = 1'b0;
    logic        rte_strobe = 1'b0;
    logic        psw_wr_en = 1'b0;
    logic [2:0]  psw_wr_data = '0;
    logic        redirect_valid, irq_ack;
    logic [31:0] redirect_target, bpc;
    logic        status_sm, status_ie, status_c, bak_sm, bak_ie, bak_c;

    int        errors = 0;
    int        checks = 0;
    exp_item_t exp_q[$];

    always #4 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n),
        .retire_valid(retire_valid), .retire_addr(retire_addr),
        .retire_is32(retire_is32), .retire_branch(retire_branch),
        .retire_next_pc(retire_next_pc), .irq_req(irq_req),
        .flash_mode(flash_mode), .rte_strobe(rte_strobe),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .redirect_valid(redirect_valid), .redirect_target(redirect_target),
        .irq_ack(irq_ack),
        .status_sm(status_sm), .status_ie(status_ie), .status_c(status_c),
        .bak_sm(bak_sm), .bak_ie(bak_ie), .bak_c(bak_c), .bpc(bpc)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Monitor: every redirect is compared against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2/R3/R4/R8: actual=unexpected redirect 0x%08h expected=none",
                         redirect_target);
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                if (redirect_target !== e.target || irq_ack !== e.ack) begin
                    errors++;
                    $display("FAIL %s: actual=0x%08h/ack%0b expected=0x%08h/ack%0b",
                             e.req, redirect_target, irq_ack, e.target, e.ack);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, then one idle cycle. Expected redirects
    // are queued before the edge that produces them.
    task automatic drive(logic [31:0] addr, logic is32, logic br, logic [31:0] nxt,
                         logic irq, logic fl, logic rte, logic wr, logic [2:0] wd,
                         logic expect_rd, logic [31:0] exp_tgt, logic exp_ack, string req);
        exp_item_t e;
        if (expect_rd) begin
            e.target = exp_tgt; e.ack = exp_ack; e.req = req;
            exp_q.push_back(e);
        end
        retire_valid   = (addr != 32'hFFFF_FFFF);
        retire_addr    = addr;
        retire_is32    = is32;
        retire_branch  = br;
        retire_next_pc = nxt;
        irq_req        = irq;
        flash_mode     = fl;
        rte_strobe     = rte;
        psw_wr_en      = wr;
        psw_wr_data    = wd;
        @(negedge clk);
        retire_valid = 1'b0; irq_req = 1'b0; flash_mode = 1'b0;
        rte_strobe = 1'b0; psw_wr_en = 1'b0; retire_branch = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_psw(string req, logic [2:0] cur, logic [2:0] bak);
        check(req, {29'd0, status_sm, status_ie, status_c}, {29'd0, cur});
        check(req, {29'd0, bak_sm, bak_ie, bak_c}, {29'd0, bak});
    endtask

    localparam logic [31:0] NONE = 32'hFFFF_FFFF;
    localparam logic [31:0] VN   = 32'h0000_0080;
    localparam logic [31:0] VF   = 32'h0080_4000;

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_psw("R1", 3'b000, 3'b000);
        check("R1", bpc, 32'h0);
        check("R1", {30'd0, redirect_valid, irq_ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 status write: SM=1 IE=1 C=1
        drive(NONE, 0, 0, 0, 0, 0, 0, 1, 3'b111, 0, 0, 0, "R10");
        chk_psw("R10", 3'b111, 3'b000);

        // R3 first-half halfword, request high: not taken
        drive(32'h100, 0, 0, 32'h102, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
        check("R3", bpc, 32'h0);
        chk_psw("R3", 3'b111, 3'b000);

        // R2 second-half halfword: accepted to normal vector
        drive(32'h102, 0, 0, 32'h104, 1, 0, 0, 0, 0, 1, VN, 1, "R2");
        chk_psw("R5", 3'b000, 3'b111);
        check("R6", bpc, 32'h104);

        // R4 IE=0 blocks a full-word retirement
        drive(32'h200, 1, 0, 32'h204, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
        check("R4", bpc, 32'h104);

        // R9 return
        drive(NONE, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h104, 0, "R9");
        chk_psw("R9", 3'b111, 3'b111);

        // R7 flash mode vector, status {0,1,0}
        drive(NONE, 0, 0, 0, 0, 0, 0, 1, 3'b010, 0, 0, 0, "R10");
        drive(32'h300, 1, 0, 32'h304, 1, 1, 0, 0, 0, 1, VF, 1, "R7");
        chk_psw("R5", 3'b000, 3'b010);
        check("R6", bpc, 32'h304);
        drive(NONE, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h304, 0, "R9");
        chk_psw("R9", 3'b010, 3'b010);

        // R2 taken halfword branch at first half; R6 target low bits cleared
        drive(32'h400, 0, 1, 32'h1002, 1, 0, 0, 0, 0, 1, VN, 1, "R2");
        check("R6", bpc, 32'h1000);
        drive(NONE, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h1000, 0, "R9");

        // R8 request drops before the boundary: lost
        drive(32'h500, 0, 0, 32'h502, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
        drive(32'h502, 0, 0, 32'h504, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        check("R8", bpc, 32'h1000);
        check("R8", {31'd0, status_ie}, 32'h1);
        drive(32'h504, 1, 0, 32'h508, 1, 0, 0, 0, 0, 1, VN, 1, "R2");
        check("R6", bpc, 32'h508);
        drive(NONE, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h508, 0, "R9");

        // R10 write colliding with accept: accept wins
        drive(32'h600, 1, 0, 32'h604, 1, 0, 0, 1, 3'b101, 1, VN, 1, "R10");
        chk_psw("R10", 3'b000, 3'b010);
        drive(NONE, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h604, 0, "R9");

        // R9 return strobe with acceptable request: return wins
        drive(32'h700, 1, 0, 32'h704, 1, 0, 1, 0, 0, 1, 32'h604, 0, "R9");
        check("R9", bpc, 32'h604);
        chk_psw("R9", 3'b010, 3'b010);

        repeat (2) @(negedge clk);
        check("R2", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule